// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a two-wire serial slave that holds a bank of byte-wide configuration registers (29 by default) and exports them to the rest of the chip as one flat vector. A host updates it with block writes only. After the write address, the host sends two more bytes, a command code and a byte count. Both must be sent and both are acknowledged, but neither value is used. Every data byte that follows lands in the next register, always starting from register 0. The host may end the transfer with a STOP after any complete byte.

A read transaction returns a count byte first. That count is the value of register 6. The block then sends registers 0, 1, 2 and so on, for as many bytes as the count allows. A few multi-byte fields are protected: the bytes of such a group are held in a staging copy and reach the live registers together, only when the group's last byte is written. Bus lines are oversampled by the system clock. SDA is driven through an open-drain enable, and the slave never stretches the clock.

Top module: `serial_cfg_bank`

## Requirements
- R1: The address byte 0xD2 (write) and the address byte 0xD3 (read) are acknowledged by holding SDA low during the ninth clock. Any other address is not acknowledged, and the slave ignores the rest of that transaction.
- R2: In a write, the first two bytes after the address are acknowledged and discarded whatever their value. The third byte goes to register 0 and each further byte goes to the next register.
- R3: Each data byte takes effect when it is received. A STOP after any complete byte keeps the bytes already written and leaves all later registers unchanged.
- R4: In a read, the slave sends the value of register 6 as a count N, most significant bit first. It then sends registers 0 to N-1 while the host acknowledges. Positions at or past N, or past the last register, read as 0xFF. A host NACK ends the read with SDA released.
- R5: Register 6 resets to 0x06. A write of 0x00 to register 6 is ignored.
- R6: The register groups {14,15}, {16,17} and {18,19,20} change only when the group's last register is written. All registers of the group then change together, to the values written in the same transaction. A transfer that stops part-way through a group leaves the whole group unchanged.
- R7: Register 7 reads as {3'b000, inverted strap_i} with strap_i captured while reset is asserted. Register 11 reads as 0x01 (vendor nibble 0001 in bits 3:0). Writes to registers 7 and 11 have no effect.
- R8: Data bytes addressed past the last register are acknowledged and discarded.
- R9: After reset, every register other than 6, 7 and 11 holds 0x00. Register k appears on cfg_o[8k+7:8k].
- R10: The slave turns on its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset; the strap inputs are captured while it is low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 5 | Frequency-select straps, read back inverted in register 7 |
| sda_oe_o | output | 1 | When 1, pulls SDA low (open-drain) |
| cfg_o | output | 232 | Current register values, register k in bits 8k+7:8k |

## Verification
The bench sweeps a set of near-miss addresses, such as 0xD0 and 0xD4, and addresses with only the upper bit flipped. A decoder that compared too few bits would acknowledge them. It then writes and reads past the end of the bank and past the count set in register 6. An off-by-one in the index would shift every byte, or would return register data where 0xFF is due. It stops writes in the middle of each protected group, one byte short of the group's end. A design that committed bytes as they arrived would show torn values there. The remaining cases are a zero written to the count register and writes aimed at the two read-only registers. Either one would be visible at cfg_o and in the readback if the write were taken.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } bus_state_e;

    localparam logic [6:0] DEV_ADDR  = 7'h69;   // 0xD2 write, 0xD3 read
    localparam int         STRAP_W   = 5;
    localparam int         IDX_COUNT = 6;
    localparam int         IDX_STRAP = 7;
    localparam int         IDX_ID    = 11;

    localparam int GRP_COUNT = 3;
    localparam int GRP_FIRST [GRP_COUNT] = '{14, 16, 18};
    localparam int GRP_LAST  [GRP_COUNT] = '{15, 17, 20};

    // Group number owning register idx, or -1 when it is ungrouped.
    function automatic int grp_of(input int idx);
        for (int g = 0; g < GRP_COUNT; g++) begin
            if (idx >= GRP_FIRST[g] && idx <= GRP_LAST[g]) return g;
        end
        return -1;
    endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh   = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_sh[STAGES-1];
        d.sda_prev = q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_o      = q.scl_sh[STAGES-1];
    assign sda_o      = q.sda_sh[STAGES-1];
    assign scl_rise_o = scl_o & ~q.scl_prev;
    assign scl_fall_o = ~scl_o & q.scl_prev;
    assign start_o    = scl_o & q.scl_prev & q.sda_prev & ~sda_o;
    assign stop_o     = scl_o & q.scl_prev & ~q.sda_prev & sda_o;

endmodule

// File: rtl/scfg_bank.sv
module scfg_bank
    import scfg_pkg::*;
#(
    parameter int         NUM_REGS = 29,
    parameter int         IW       = 7,
    parameter logic [3:0] ID_HI    = 4'h0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [STRAP_W-1:0]    strap_i,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IW-1:0]         rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    typedef struct {
        logic [7:0]         live  [NUM_REGS];
        logic [7:0]         stage [NUM_REGS];
        logic [STRAP_W-1:0] strap;
    } bank_t;

    bank_t q, d;
    logic [7:0] view [NUM_REGS];

    always_comb begin
        d = q;
        for (int j = 0; j < NUM_REGS; j++) begin : reg_upd
            int   g;
            logic hit;
            g   = grp_of(j);
            hit = wr_en && (wr_idx == IW'(j));
            if (g < 0) begin
                if (hit && j != IDX_STRAP && j != IDX_ID &&
                    !(j == IDX_COUNT && wr_data == 8'h00))
                    d.live[j] = wr_data;
            end else begin
                if (hit) d.stage[j] = wr_data;
                if (wr_en && wr_idx == IW'(GRP_LAST[g]))
                    d.live[j] = (j == GRP_LAST[g]) ? wr_data : q.stage[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_REGS; j++) begin
                q.live[j]  <= (j == IDX_COUNT) ? 8'h06 : 8'h00;
                q.stage[j] <= 8'h00;
            end
            q.strap <= strap_i;
        end else begin
            q <= d;
        end
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_view
        if (k == IDX_STRAP) begin : g_strap
            assign view[k] = {{(8-STRAP_W){1'b0}}, ~q.strap};
        end else if (k == IDX_ID) begin : g_id
            assign view[k] = {ID_HI, 4'b0001};
        end else begin : g_rw
            assign view[k] = q.live[k];
        end
        assign cfg_o[8*k +: 8] = view[k];
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == IW'(k)) rd_data = view[k];
        end
    end

    // R5
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.live[IDX_COUNT] != 8'h00);

    // R6
    grp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IW'(GRP_FIRST[0])) |=> $stable(q.live[GRP_FIRST[0]]));

    // R8
    past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IW'(NUM_REGS)) |=> $stable(cfg_o));

endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank
    import scfg_pkg::*;
#(
    parameter int         NUM_REGS    = 29,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] ID_HI       = 4'h0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [STRAP_W-1:0]    strap_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam int IW = $clog2(NUM_REGS) + 2;

    typedef struct packed {
        bus_state_e    st;
        logic [3:0]    bits;
        logic [7:0]    sh;
        logic          rd;
        logic          oe;
        logic          acked;
        logic [IW-1:0] pos;
    } ctl_t;

    ctl_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic          wr_en;
    logic [IW-1:0] wr_idx, rd_idx, pos_inc;
    logic [7:0]    rd_data, cnt_w, rd_next;

    scfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(bus_start), .stop_o(bus_stop)
    );

    scfg_bank #(.NUM_REGS(NUM_REGS), .IW(IW), .ID_HI(ID_HI)) u_bank (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(q.sh),
        .rd_idx(rd_idx), .rd_data(rd_data), .cfg_o(cfg_o)
    );

    assign cnt_w   = cfg_o[IDX_COUNT*8 +: 8];
    assign wr_idx  = q.pos - IW'(2);
    assign rd_idx  = q.pos - IW'(1);
    assign pos_inc = (q.pos == '1) ? q.pos : q.pos + IW'(1);

    always_comb begin
        if (q.pos == '0)                       rd_next = cnt_w;
        else if (int'(rd_idx) < int'(cnt_w))   rd_next = rd_data;
        else                                   rd_next = 8'hFF;
    end

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (bus_start) begin
            d.st   = ST_ADDR;
            d.bits = '0;
            d.oe   = 1'b0;
            d.pos  = '0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_WR: begin
                    if (scl_rise) begin
                        d.sh   = {q.sh[6:0], sda_s};
                        d.bits = q.bits + 4'd1;
                    end
                    if (scl_fall && q.bits == 4'd8) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.st = ST_ADDR_ACK;
                                d.oe = 1'b1;
                                d.rd = q.sh[0];
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st  = ST_WR_ACK;
                            d.oe  = 1'b1;
                            wr_en = (q.pos >= IW'(2));
                            d.pos = pos_inc;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.bits = '0;
                        if (q.rd) begin
                            d.st  = ST_RD;
                            d.sh  = rd_next;
                            d.oe  = ~rd_next[7];
                            d.pos = pos_inc;
                        end else begin
                            d.st = ST_WR;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.st   = ST_WR;
                        d.oe   = 1'b0;
                        d.bits = '0;
                    end
                end
                ST_RD: begin
                    if (scl_rise) d.bits = q.bits + 4'd1;
                    if (scl_fall) begin
                        if (q.bits == 4'd8) begin
                            d.st = ST_RD_ACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) d.acked = ~sda_s;
                    if (scl_fall) begin
                        if (q.acked) begin
                            d.st   = ST_RD;
                            d.sh   = rd_next;
                            d.oe   = ~rd_next[7];
                            d.bits = '0;
                            d.pos  = pos_inc;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

    // R10
    sda_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_s);

    // R4
    host_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RD_ACK) |-> !q.oe);

    // R1
    addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR_ACK) |-> (q.sh[7:1] == DEV_ADDR));

endmodule

// File: tb/serial_cfg_bank_test.sv
module serial_cfg_bank_test;
    localparam int T     = 10;
    localparam int HALF  = 60;
    localparam int QTR   = 20;
    localparam int NREG  = 29;
    localparam int WD_CYC = 150000;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, host_sda = 1'b1;
    logic [4:0] strap = 5'b10110;
    logic sda_line, sda_oe;
    logic [NREG*8-1:0] cfg;

    int n_run = 0, n_fail = 0, oe_viol = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] mdl [NREG];
    logic [7:0] stg [NREG];
    logic [7:0] tx  [40];

    assign sda_line = host_sda & ~sda_oe;

    serial_cfg_bank uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap_i(strap), .sda_oe_o(sda_oe), .cfg_o(cfg)
    );

    always #(T/2) clk = ~clk;

    always @(negedge clk) begin
        if (sda_oe && !prev_oe && scl) oe_viol++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void model_put(input int idx, input logic [7:0] v);
        if (idx >= NREG || idx == 7 || idx == 11) return;
        if (idx == 6 && v == 8'h00) return;
        if (idx == 14 || idx == 16 || idx == 18 || idx == 19) stg[idx] = v;
        else if (idx == 15) begin mdl[14] = stg[14]; mdl[15] = v; end
        else if (idx == 17) begin mdl[16] = stg[16]; mdl[17] = v; end
        else if (idx == 20) begin mdl[18] = stg[18]; mdl[19] = stg[19]; mdl[20] = v; end
        else mdl[idx] = v;
    endfunction

    task automatic bus_start();
        host_sda = 1'b1; scl = 1'b1; #(HALF);
        host_sda = 1'b0; #(HALF);
        scl = 1'b0; #(QTR);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; #(HALF);
        scl = 1'b1; #(HALF);
        host_sda = 1'b1; #(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; #(HALF);
            scl = 1'b1; #(HALF);
            scl = 1'b0; #(QTR);
        end
        host_sda = 1'b1; #(HALF);
        scl = 1'b1; #(QTR);
        ack = ~sda_line; #(HALF-QTR);
        scl = 1'b0; #(QTR);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #(HALF); scl = 1'b1; #(QTR);
            b[i] = sda_line; #(HALF-QTR);
            scl = 1'b0; #(QTR);
        end
        host_sda = nack; #(HALF);
        scl = 1'b1; #(HALF);
        scl = 1'b0; #(QTR);
        host_sda = 1'b1;
    endtask

    // Block write: address, command, count, then n bytes from tx[].
    task automatic do_write(input logic [7:0] cmd, input logic [7:0] cnt, input int n);
        logic a;
        int nacks = 0;
        bus_start();
        send_byte(8'hD2, a);
        chk(a, "R1 write address ack", a, 1);
        send_byte(cmd, a); if (!a) nacks++;
        send_byte(cnt, a); if (!a) nacks++;
        chk(nacks == 0, "R2 command/count ack", nacks, 0);
        for (int i = 0; i < n; i++) begin
            send_byte(tx[i], a);
            if (!a) nacks++;
            model_put(i, tx[i]);
        end
        bus_stop();
        chk(nacks == 0, (n > NREG) ? "R8 all data bytes ack" : "R2 all data bytes ack", nacks, 0);
    endtask

    task automatic do_read(input int n);
        logic a;
        logic [7:0] b, e;
        bus_start();
        send_byte(8'hD3, a);
        chk(a, "R1 read address ack", a, 1);
        recv_byte(1'b0, b);
        chk(b == mdl[6], "R4 count byte", b, mdl[6]);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            e = (k < int'(mdl[6]) && k < NREG) ? mdl[k] : 8'hFF;
            chk(b == e, $sformatf("R4 read byte %0d", k), b, e);
        end
        bus_stop();
        chk(sda_oe == 1'b0, "R4 released after nack", sda_oe, 0);
    endtask

    task automatic check_cfg(input string tag);
        for (int k = 0; k < NREG; k++)
            chk(cfg[8*k +: 8] == mdl[k], $sformatf("%s reg %0d", tag, k), cfg[8*k +: 8], mdl[k]);
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) begin mdl[k] = 8'h00; stg[k] = 8'h00; end
        mdl[6]  = 8'h06;
        mdl[7]  = {3'b000, ~strap};
        mdl[11] = 8'h01;

        #(T*5 + 3);
        rst_n = 1'b1;
        #(T*5);

        // R9 R5 R7 reset contents
        check_cfg("R9 reset");
        chk(cfg[8*7 +: 8] == 8'h09, "R7 strap readback", cfg[8*7 +: 8], 8'h09);

        // R4 default readback length
        do_read(8);

        // R1 near-miss address sweep, trailing bytes ignored
        begin
            logic [7:0] bad [8] = '{8'hD0, 8'hD1, 8'hD4, 8'hD6, 8'h52, 8'h53, 8'hF2, 8'h92};
            logic a;
            for (int i = 0; i < 8; i++) begin
                bus_start();
                send_byte(bad[i], a);
                chk(!a, $sformatf("R1 no ack for %0h", bad[i]), a, 0);
                send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'hAA, a);
                chk(!a, "R1 ignored data no ack", a, 0);
                bus_stop();
            end
            check_cfg("R1 unchanged");
        end

        // R2 R8 full write plus two bytes past the end
        for (int i = 0; i < 31; i++) tx[i] = 8'((i * 37 + 11) & 255);
        do_write(8'h5A, 8'h99, 31);
        check_cfg("R2 full write");

        // R5 zero to count register ignored
        for (int i = 0; i < 7; i++) tx[i] = 8'h00;
        do_write(8'hFF, 8'h00, 7);
        chk(cfg[8*6 +: 8] == 8'(6 * 37 + 11), "R5 zero count ignored", cfg[8*6 +: 8], 8'(6 * 37 + 11));
        check_cfg("R5 after zero");

        // R4 long read past count and past the bank
        for (int i = 0; i < 6; i++) tx[i] = mdl[i];
        tx[6] = 8'd31;
        do_write(8'h00, 8'h07, 7);
        do_read(33);

        // R6 partial groups
        for (int i = 0; i < 21; i++) tx[i] = 8'((i * 91 + 3) & 255);
        tx[6] = 8'd31;
        do_write(8'h01, 8'h02, 15);
        check_cfg("R6 stop inside 14-15");
        do_write(8'h01, 8'h02, 17);
        check_cfg("R6 stop inside 16-17");
        for (int i = 14; i < 21; i++) tx[i] = 8'((i * 13 + 200) & 255);
        do_write(8'h01, 8'h02, 20);
        check_cfg("R6 stop inside 18-20");
        do_write(8'h01, 8'h02, 21);
        check_cfg("R6 full groups");
        do_read(22);

        // R7 read-only registers
        for (int i = 0; i < 12; i++) tx[i] = mdl[i];
        tx[6] = 8'd3; tx[7] = 8'hFF; tx[11] = 8'hEE;
        do_write(8'h33, 8'h44, 12);
        check_cfg("R7 read-only");

        // R4 short count
        do_read(5);

        // R3 stop after one data byte
        tx[0] = 8'hC3;
        do_write(8'h10, 8'h20, 1);
        check_cfg("R3 single byte");

        // R10 drive only while SCL low
        chk(oe_viol == 0, "R10 drive during SCL high", oe_viol, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule